// File: doc/BRIEF.md
# Typed Flit Packetizer

This block sits between a producing module and a data network. Each word handed to it carries a 2-bit data type, a 3-bit destination port, a 3-bit fixed-point position field and a payload of up to 56 bits. The type fixes how many payload bytes are meaningful. The block frames the word as one header byte, the payload bytes and one closing byte. It queues the framed packet and then streams it out one 8-bit flit per transfer on a valid/ready interface.

A single clock drives the whole block. Output backpressure replaces any per-type rate generation. Input acceptance stops while the packet queue is full. Because every queue slot is sized for the largest packet, one free slot is always enough for any incoming word.

Top module: `flit_packer`

## Requirements
- R1: The first flit of each packet is the header byte: bits [7:6] hold the type code, bits [5:3] the destination port and bits [2:0] the fixed-point position field.
- R2: The type code sets the payload length: 2'b00 carries 7 bytes, 2'b01 and 2'b10 carry 6 bytes, and 2'b11 carries 1 byte. The payload is taken from the low-order bits of `in_payload`. Input bits above the payload length have no effect on the output.
- R3: Payload bytes leave most significant byte first, directly after the header.
- R4: Every packet ends with the byte 8'hFF, so a packet is 9, 8, 8 or 3 flits long for type codes 2'b00, 2'b01, 2'b10 and 2'b11.
- R5: `out_last` is high exactly while the closing byte is presented.
- R6: A flit advances only on a cycle where `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` stays high and `out_flit` holds its value.
- R7: With the output stalled from reset, exactly DEPTH+1 back-to-back words are accepted (DEPTH queued plus one being serialized). After that `in_ready` stays low.
- R8: Packets leave in the order they were accepted. When packets are queued and `out_ready` stays high, the next header follows the previous closing byte with no idle cycle.
- R9: After reset `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present |
| in_ready | output | 1 | Block can accept a word this cycle |
| in_type | input | 2 | Data type code |
| in_port | input | 3 | Destination port number |
| in_ilen | input | 3 | Fixed-point position |
| in_payload | input | 56 | Payload, right-aligned |
| out_valid | output | 1 | Flit present |
| out_ready | input | 1 | Receiver takes the flit |
| out_flit | output | 8 | Flit byte |
| out_last | output | 1 | Flit is the closing byte |

## Verification
The bench drives the short packet types with random high-order payload bits. A design that sliced the wrong bits, or that let those bits leak into the frame, would emit payload bytes that do not match. Random stalls on `out_ready` would expose a serializer that skipped or repeated a flit, or that let the byte change while stalled. A directed fill with the output held off checks that exactly one more word than the queue depth is taken. A following drain with `out_ready` held high catches an idle bubble between a closing byte and the next header. A design that lost the reload on the last transfer would show that bubble.

// File: rtl/flit_pkg.sv
package flit_pkg;
    localparam int FLIT_W    = 8;
    localparam int PAYLOAD_W = 56;
    localparam int PKT_W     = PAYLOAD_W + 2 * FLIT_W;
    localparam int CNT_W     = 4;
    localparam logic [FLIT_W-1:0] TAIL_BYTE = 8'hFF;

    typedef enum logic [1:0] {
        T_COEF = 2'b00,
        T_ORIG = 2'b01,
        T_CMPR = 2'b10,
        T_RSLT = 2'b11
    } dtype_e;

    typedef struct packed {
        logic [CNT_W-1:0] flits;
        logic [PKT_W-1:0] bits;
    } pkt_t;

    localparam int ENTRY_W = CNT_W + PKT_W;

    function automatic int payload_bytes(logic [1:0] t);
        case (dtype_e'(t))
            T_COEF:  return 7;
            T_ORIG:  return 6;
            T_CMPR:  return 6;
            default: return 1;
        endcase
    endfunction
endpackage

// File: rtl/pkt_framer.sv
module pkt_framer
    import flit_pkg::*;
(
    input  logic [1:0]           typ,
    input  logic [2:0]           port,
    input  logic [2:0]           ilen,
    input  logic [PAYLOAD_W-1:0] payload,
    output pkt_t                 pkt
);
    localparam int MAX_BYTES = PAYLOAD_W / FLIT_W;

    logic [FLIT_W-1:0]    hdr;
    logic [PAYLOAD_W-1:0] aligned;
    logic [PKT_W-1:0]     tail_vec;
    int                   nb;
    int                   gap;

    always_comb begin
        nb       = payload_bytes(typ);
        gap      = FLIT_W * (MAX_BYTES - nb);
        hdr      = {typ, port, ilen};
        aligned  = payload << gap;
        tail_vec = {{(PKT_W-FLIT_W){1'b0}}, TAIL_BYTE} << gap;
        pkt.bits  = {hdr, aligned, {FLIT_W{1'b0}}} | tail_vec;
        pkt.flits = CNT_W'(nb + 2);
    end
endmodule

// File: rtl/pkt_fifo.sv
module pkt_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 76
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    input  logic         rd_en,
    output logic [W-1:0] rd_data,
    output logic         full,
    output logic         empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [AW:0] wp;
        logic [AW:0] rp;
    } ptr_t;

    ptr_t         q, d;
    logic [W-1:0] mem [DEPTH];

    always_comb begin
        d = q;
        if (wr_en) d.wp = q.wp + 1'b1;
        if (rd_en) d.rp = q.rp + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[q.wp[AW-1:0]] <= wr_data;
    end

    assign rd_data = mem[q.rp[AW-1:0]];
    assign empty   = (q.wp == q.rp);
    assign full    = (q.wp[AW] != q.rp[AW]) && (q.wp[AW-1:0] == q.rp[AW-1:0]);

    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) wr_en |-> !full);  // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) rd_en |-> !empty); // R8
endmodule

// File: rtl/flit_slicer.sv
module flit_slicer
    import flit_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  pkt_t              entry,
    input  logic              empty,
    output logic              pop,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [FLIT_W-1:0] out_flit,
    output logic              out_last
);
    typedef struct packed {
        logic             busy;
        logic [PKT_W-1:0] sh;
        logic [CNT_W-1:0] left;
    } sl_t;

    sl_t  q, d;
    logic xfer;

    always_comb begin
        d    = q;
        pop  = 1'b0;
        xfer = q.busy && out_ready;
        if (xfer) begin
            d.sh   = q.sh << FLIT_W;
            d.left = q.left - 1'b1;
            if (q.left == CNT_W'(1)) d.busy = 1'b0;
        end
        if (!d.busy && !empty) begin
            pop    = 1'b1;
            d.busy = 1'b1;
            d.sh   = entry.bits;
            d.left = entry.flits;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.busy;
    assign out_flit  = q.sh[PKT_W-1 -: FLIT_W];
    assign out_last  = q.busy && (q.left == CNT_W'(1));

    AST_HOLD_FLIT: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_flit)));           // R6
    AST_TAIL_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_last) |-> (out_flit == TAIL_BYTE));                       // R4
    AST_LEFT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (q.left != '0 && q.left <= CNT_W'(PKT_W / FLIT_W)));           // R4
endmodule

// File: rtl/flit_packer.sv
module flit_packer
    import flit_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [1:0]           in_type,
    input  logic [2:0]           in_port,
    input  logic [2:0]           in_ilen,
    input  logic [PAYLOAD_W-1:0] in_payload,
    output logic                 out_valid,
    input  logic                 out_ready,
    output logic [FLIT_W-1:0]    out_flit,
    output logic                 out_last
);
    pkt_t framed;
    pkt_t head;
    logic full, empty, pop, push;

    pkt_framer u_framer (
        .typ     (in_type),
        .port    (in_port),
        .ilen    (in_ilen),
        .payload (in_payload),
        .pkt     (framed)
    );

    assign in_ready = !full;
    assign push     = in_valid && in_ready;

    pkt_fifo #(.DEPTH(DEPTH), .W(ENTRY_W)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (push),
        .wr_data (framed),
        .rd_en   (pop),
        .rd_data (head),
        .full    (full),
        .empty   (empty)
    );

    flit_slicer u_slicer (
        .clk       (clk),
        .rst_n     (rst_n),
        .entry     (head),
        .empty     (empty),
        .pop       (pop),
        .out_valid (out_valid),
        .out_ready (out_ready),
        .out_flit  (out_flit),
        .out_last  (out_last)
    );

    AST_ACCEPT_SETS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !out_valid) |=> ##1 out_valid);                                    // R8
endmodule

// File: tb/flit_packer_tb.sv
module flit_packer_tb_top;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [1:0]  in_type = '0;
    logic [2:0]  in_port = '0;
    logic [2:0]  in_ilen = '0;
    logic [55:0] in_payload = '0;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [7:0]  out_flit;
    logic        out_last;

    always #2 clk = ~clk;

    flit_packer #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_type(in_type), .in_port(in_port), .in_ilen(in_ilen),
        .in_payload(in_payload), .out_valid(out_valid), .out_ready(out_ready),
        .out_flit(out_flit), .out_last(out_last)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic [7:0] exp_flit [4096];
    bit         exp_last [4096];
    int         exp_kind [4096];
    int         wr_i = 0;
    int         rd_i = 0;

    int         rdy_mode = 0;
    int         gaps = 0;
    bit         was_stalled = 0;
    logic [7:0] stall_flit = '0;

    function automatic int nbytes(logic [1:0] t);
        return (t == 2'b00) ? 7 : (t == 2'b11) ? 1 : 6;
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic push_exp(logic [1:0] t, logic [2:0] p, logic [2:0] l, logic [55:0] pl);
        int nb = nbytes(t);
        exp_flit[wr_i] = {t, p, l}; exp_last[wr_i] = 0; exp_kind[wr_i] = 0; wr_i++;
        for (int i = nb - 1; i >= 0; i--) begin
            exp_flit[wr_i] = pl[i*8 +: 8]; exp_last[wr_i] = 0; exp_kind[wr_i] = 1; wr_i++;
        end
        exp_flit[wr_i] = 8'hFF; exp_last[wr_i] = 1; exp_kind[wr_i] = 2; wr_i++;
    endtask

    // called at a negedge; returns at a later negedge with in_valid still high
    task automatic send(logic [1:0] t, logic [2:0] p, logic [2:0] l, logic [55:0] pl);
        in_type = t; in_port = p; in_ilen = l; in_payload = pl; in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        push_exp(t, p, l, pl);
        @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (was_stalled) begin
                check(out_valid === 1'b1, "R6 valid held", out_valid, 1);
                check(out_flit === stall_flit, "R6 flit held", out_flit, stall_flit);
            end
            case (rdy_mode)
                0: out_ready = ($urandom_range(0, 9) < 7);
                1: out_ready = 1'b0;
                default: out_ready = 1'b1;
            endcase
            if (rdy_mode == 2 && rd_i < wr_i && !out_valid) gaps++;
            was_stalled = out_valid && !out_ready;
            stall_flit  = out_flit;
            if (out_valid && out_ready) begin
                if (rd_i >= wr_i) begin
                    check(0, "R8 unexpected flit", out_flit, 0);
                end else begin
                    case (exp_kind[rd_i])
                        0: check(out_flit === exp_flit[rd_i], "R1 header", out_flit, exp_flit[rd_i]);
                        1: check(out_flit === exp_flit[rd_i], "R2/R3 payload", out_flit, exp_flit[rd_i]);
                        default: check(out_flit === exp_flit[rd_i], "R4 tail", out_flit, exp_flit[rd_i]);
                    endcase
                    check(out_last === exp_last[rd_i], "R5 last", out_last, exp_last[rd_i]);
                    rd_i++;
                end
            end
        end
    end

    task automatic drain();
        int guard = 0;
        while (rd_i < wr_i && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        check(rd_i == wr_i, "R8 drained", rd_i, wr_i);
    endtask

    initial begin : wdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        int acc;
        int lowrun;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        check(out_valid === 1'b0, "R9 valid after reset", out_valid, 0);
        check(in_ready === 1'b1, "R9 ready after reset", in_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);

        // directed: one of each type, known bytes, junk in unused bits
        send(2'b00, 3'd5, 3'd2, 56'h0123456789ABCD);
        send(2'b01, 3'd1, 3'd7, 56'hEE_A1B2C3D4E5F6);
        send(2'b10, 3'd6, 3'd0, 56'h77_102030405060);
        send(2'b11, 3'd3, 3'd4, 56'hDEADBEEFCAFE5A);
        in_valid = 1'b0;
        drain();

        // random traffic with random output stalls
        for (int k = 0; k < 150; k++) begin
            send(2'($urandom), 3'($urandom), 3'($urandom),
                 {24'($urandom), 32'($urandom)});
            if ($urandom_range(0, 3) == 0) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
        end
        in_valid = 1'b0;
        drain();

        // R7: fill with output stalled
        rdy_mode = 1;
        @(negedge clk);
        acc = 0;
        lowrun = 0;
        for (int k = 0; k < 20 && lowrun < 4; k++) begin
            in_type = 2'b00; in_port = 3'(k); in_ilen = 3'd1;
            in_payload = {24'($urandom), 32'($urandom)};
            in_valid = 1'b1;
            if (in_ready) begin
                push_exp(in_type, in_port, in_ilen, in_payload);
                acc++;
                lowrun = 0;
            end else begin
                lowrun++;
            end
            @(negedge clk);
        end
        in_valid = 1'b0;
        check(acc == DEPTH + 1, "R7 accepted count", acc, DEPTH + 1);
        check(in_ready === 1'b0, "R7 ready low when full", in_ready, 0);

        // R8: drain with ready held high, no bubbles
        gaps = 0;
        rdy_mode = 2;
        drain();
        check(gaps == 0, "R8 no gap between packets", gaps, 0);
        check(out_valid === 1'b0, "R8 idle after drain", out_valid, 0);
        check(in_ready === 1'b1, "R7 ready after drain", in_ready, 1);

        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule